// File: doc/BRIEF.md
# Typed Branch Target Buffer

This block predicts the next fetch address of an instruction fetch unit. The fetch address is looked up every cycle in a set-associative table. Each entry records a tag, the last taken destination, a two-bit branch kind and a two-bit saturating direction counter. The lookup is purely combinational. It returns a hit flag, the stored destination, the kind and the predicted next fetch address. A hit on a return raises a flag, so that an external return stack supplies the address instead.

A single update port reports resolved branches. An entry is created only for a branch that was taken. A branch that already has an entry has its counter moved, its kind refreshed, and, when taken, its destination overwritten. A call entry therefore always holds the most recent destination of that call. New entries first use empty ways of the set, and after that a per-set round-robin pointer picks the way. The organisation is set by `ENTRIES` (32 to 512, default 256) and `WAYS` (a power of two, at least 2, default 4).

Top module: `branch_target_cache`

## Requirements
- R1: After reset every lookup misses: `hit`=0, `use_ras`=0 and `next_pc` = `fetch_pc`+4.
- R2: A taken update for an address with no entry installs it. A later lookup of that address hits and returns the destination and the kind. The kind encoding is 00 conditional, 01 jump, 10 call, 11 return.
- R3: A not-taken update for an address with no entry installs nothing. A later lookup of that address misses.
- R4: On a hit of kind 00, `next_pc` is the stored destination when the counter is 2 or 3, and `fetch_pc`+4 otherwise. A newly installed entry starts at counter 2 (weakly taken).
- R5: An update that hits increments the counter when taken, saturating at 3. It decrements the counter when not taken, saturating at 0.
- R6: A hit of kind 01 or 10 sets `next_pc` to the stored destination whatever the counter holds.
- R7: A hit of kind 11 asserts `use_ras` and sets `next_pc` to `fetch_pc`+4. The stored destination is not used for the redirect.
- R8: A taken update that hits overwrites the stored destination with the new one.
- R9: When all ways of a set are valid, installs replace ways in round-robin order. Empty ways are filled first, so the fifth distinct branch in a 4-way set evicts the first one installed.
- R10: An update takes effect at the clock edge. A lookup in the same cycle as an update sees the contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fetch_pc | input | ADDR_W | Address being fetched |
| hit | output | 1 | Lookup found an entry |
| hit_target | output | ADDR_W | Stored destination of the hit entry |
| hit_kind | output | 2 | Kind of the hit entry |
| next_pc | output | ADDR_W | Predicted next fetch address |
| use_ras | output | 1 | Hit on a return; take address from return stack |
| upd_valid | input | 1 | A resolved branch is reported |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_target | input | ADDR_W | Resolved destination |
| upd_kind | input | 2 | Kind of the resolved branch |
| upd_taken | input | 1 | Resolved branch was taken |

## Verification
A lookup and an update can land in the same cycle, and even on the same entry. The bench provokes this by holding the fetch address on an installed jump while it reports a new destination for that jump in the same cycle. It judges the result by sampling `hit_target` before the edge, where the old destination is expected, and after the edge, where the new one is expected. Counter saturation at both ends and round-robin eviction are driven as separate update sequences on their own addresses.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    KIND_COND = 2'b00,
    KIND_JUMP = 2'b01,
    KIND_CALL = 2'b10,
    KIND_RET  = 2'b11
  } br_kind_e;

  localparam logic [1:0] CTR_INIT = 2'b10;
endpackage

// File: rtl/btb_match.sv
module btb_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 24,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid[w] && (tags[w] == tag);
  end

  always_comb begin
    way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) way = WAY_W'(w);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid,
  input  logic [WAY_W-1:0] rr_ptr,
  output logic [WAY_W-1:0] victim
);
  always_comb begin
    victim = rr_ptr;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) victim = WAY_W'(w);
    end
  end
endmodule

// File: rtl/btb_redirect.sv
module btb_redirect
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic              hit,
  input  logic [1:0]        kind,
  input  logic [1:0]        ctr,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] next_pc,
  output logic              use_ras
);
  logic redirect;

  always_comb begin
    redirect = 1'b0;
    use_ras  = 1'b0;
    if (hit) begin
      unique case (br_kind_e'(kind))
        KIND_COND: redirect = ctr[1];
        KIND_JUMP,
        KIND_CALL: redirect = 1'b1;
        KIND_RET:  use_ras  = 1'b1;
      endcase
    end
    next_pc = redirect ? target : pc + ADDR_W'(4);
  end
endmodule

// File: rtl/branch_target_cache.sv
module branch_target_cache
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 256,
  parameter int WAYS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              hit,
  output logic [ADDR_W-1:0] hit_target,
  output logic [1:0]        hit_kind,
  output logic [ADDR_W-1:0] next_pc,
  output logic              use_ras,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic [1:0]        upd_kind,
  input  logic              upd_taken
);
  localparam int SETS  = ENTRIES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - 2 - IDX_W;

  logic [WAYS-1:0]              valid_q [SETS];
  logic [WAY_W-1:0]             rr_q    [SETS];
  logic [WAYS-1:0][TAG_W-1:0]   tag_q   [SETS];
  logic [WAYS-1:0][ADDR_W-1:0]  tgt_q   [SETS];
  logic [WAYS-1:0][1:0]         kind_q  [SETS];
  logic [WAYS-1:0][1:0]         ctr_q   [SETS];

  // lookup path
  logic [IDX_W-1:0] f_set;
  logic [TAG_W-1:0] f_tag;
  logic [WAY_W-1:0] f_way;
  assign f_set = fetch_pc[IDX_W+1:2];
  assign f_tag = fetch_pc[ADDR_W-1:IDX_W+2];

  btb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_fetch_match (
    .valid(valid_q[f_set]), .tags(tag_q[f_set]), .tag(f_tag),
    .hit(hit), .way(f_way)
  );

  assign hit_target = tgt_q[f_set][f_way];
  assign hit_kind   = kind_q[f_set][f_way];

  btb_redirect #(.ADDR_W(ADDR_W)) i_redirect (
    .pc(fetch_pc), .hit(hit), .kind(hit_kind), .ctr(ctr_q[f_set][f_way]),
    .target(hit_target), .next_pc(next_pc), .use_ras(use_ras)
  );

  // update path
  logic [IDX_W-1:0] upd_set;
  logic [TAG_W-1:0] upd_tag;
  logic             upd_hit;
  logic [WAY_W-1:0] upd_way;
  logic [WAY_W-1:0] victim;
  logic             alloc_en;
  logic             wr_en;
  logic [WAY_W-1:0] wr_way;
  logic [1:0]       ctr_old;
  logic [1:0]       ctr_nxt;

  assign upd_set = upd_pc[IDX_W+1:2];
  assign upd_tag = upd_pc[ADDR_W-1:IDX_W+2];

  btb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_upd_match (
    .valid(valid_q[upd_set]), .tags(tag_q[upd_set]), .tag(upd_tag),
    .hit(upd_hit), .way(upd_way)
  );

  btb_victim #(.WAYS(WAYS)) i_victim (
    .valid(valid_q[upd_set]), .rr_ptr(rr_q[upd_set]), .victim(victim)
  );

  always_comb begin
    alloc_en = upd_valid && !upd_hit && upd_taken;
    wr_en    = upd_valid && (upd_hit || upd_taken);
    wr_way   = upd_hit ? upd_way : victim;
    ctr_old  = ctr_q[upd_set][upd_way];
    if (!upd_hit)                      ctr_nxt = CTR_INIT;
    else if (upd_taken)                ctr_nxt = (ctr_old == 2'b11) ? ctr_old : ctr_old + 2'b01;
    else                               ctr_nxt = (ctr_old == 2'b00) ? ctr_old : ctr_old - 2'b01;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '{default: '0};
      rr_q    <= '{default: '0};
    end else if (alloc_en) begin
      valid_q[upd_set][victim] <= 1'b1;
      rr_q[upd_set]            <= victim + WAY_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[upd_set][wr_way]  <= upd_tag;
      kind_q[upd_set][wr_way] <= upd_kind;
      ctr_q[upd_set][wr_way]  <= ctr_nxt;
      if (upd_taken) tgt_q[upd_set][wr_way] <= upd_target;
    end
  end

  // R1/R6/R7: a miss or a return never redirects to a stored destination
  assert_fallthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit || hit_kind == KIND_RET) |-> next_pc == fetch_pc + ADDR_W'(4));
  assert_ret_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    use_ras |-> (hit && hit_kind == KIND_RET));
  // R3: a not-taken miss leaves the valid bits of its set untouched
  assert_no_alloc_nt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && !upd_hit) |=>
      valid_q[$past(upd_set)] == $past(valid_q[upd_set]));
  // R5: saturation at both ends
  assert_ctr_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_hit && upd_taken && ctr_old == 2'b11) |=>
      ctr_q[$past(upd_set)][$past(upd_way)] == 2'b11);
  assert_ctr_bottom_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_hit && !upd_taken && ctr_old == 2'b00) |=>
      ctr_q[$past(upd_set)][$past(upd_way)] == 2'b00);
  // R2: an install makes the address hit on the next cycle
  assert_install_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> valid_q[$past(upd_set)][$past(victim)]);
endmodule

// File: tb/test_branch_target_cache.sv
module test_branch_target_cache;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic          hit;
  logic [AW-1:0] hit_target;
  logic [1:0]    hit_kind;
  logic [AW-1:0] next_pc;
  logic          use_ras;
  logic          upd_valid = 1'b0;
  logic [AW-1:0] upd_pc = '0;
  logic [AW-1:0] upd_target = '0;
  logic [1:0]    upd_kind = '0;
  logic          upd_taken = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  branch_target_cache i_branch_target_cache (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .hit(hit),
    .hit_target(hit_target), .hit_kind(hit_kind), .next_pc(next_pc),
    .use_ras(use_ras), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_target(upd_target), .upd_kind(upd_kind), .upd_taken(upd_taken)
  );

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic upd(logic [AW-1:0] pc, logic [AW-1:0] tgt, logic [1:0] k, logic tk);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_target = tgt; upd_kind = k; upd_taken = tk;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic look(logic [AW-1:0] pc);
    @(negedge clk);
    fetch_pc = pc;
    #1;
  endtask

  task automatic t_reset;
    look(32'h1000);
    chk("R1 hit", AW'(hit), 0);
    chk("R1 next_pc", next_pc, 32'h1004);
    chk("R1 use_ras", AW'(use_ras), 0);
  endtask

  task automatic t_not_taken_miss;
    upd(32'h1008, 32'h7000, 2'b00, 1'b0);
    look(32'h1008);
    chk("R3 hit", AW'(hit), 0);
    chk("R3 next_pc", next_pc, 32'h100C);
  endtask

  task automatic t_install;
    upd(32'h1000, 32'h2000, 2'b00, 1'b1);
    look(32'h1000);
    chk("R2 hit", AW'(hit), 1);
    chk("R2 target", hit_target, 32'h2000);
    chk("R2 kind", AW'(hit_kind), 0);
    chk("R4 weak taken", next_pc, 32'h2000);
  endtask

  task automatic t_counter;
    // from 2: three not-taken -> 0, one taken -> 1, another -> 2
    for (int i = 0; i < 3; i++) upd(32'h1000, 32'h2000, 2'b00, 1'b0);
    look(32'h1000);
    chk("R4 ctr0 fall-through", next_pc, 32'h1004);
    upd(32'h1000, 32'h2000, 2'b00, 1'b1);
    look(32'h1000);
    chk("R5 low saturation", next_pc, 32'h1004);
    upd(32'h1000, 32'h2000, 2'b00, 1'b1);
    look(32'h1000);
    chk("R5 up count", next_pc, 32'h2000);
    // from 2: four taken -> 3, one not-taken -> 2, another -> 1
    for (int i = 0; i < 4; i++) upd(32'h1000, 32'h2000, 2'b00, 1'b1);
    upd(32'h1000, 32'h2000, 2'b00, 1'b0);
    look(32'h1000);
    chk("R5 high saturation", next_pc, 32'h2000);
    upd(32'h1000, 32'h2000, 2'b00, 1'b0);
    look(32'h1000);
    chk("R5 down count", next_pc, 32'h1004);
  endtask

  task automatic t_jump_call;
    upd(32'h1010, 32'h3000, 2'b01, 1'b1);
    upd(32'h1010, 32'h3000, 2'b01, 1'b0);
    upd(32'h1010, 32'h3000, 2'b01, 1'b0);
    look(32'h1010);
    chk("R6 jump ignores counter", next_pc, 32'h3000);
    upd(32'h1040, 32'h4000, 2'b10, 1'b1);
    look(32'h1040);
    chk("R6 call kind", AW'(hit_kind), 2);
    chk("R6 call redirect", next_pc, 32'h4000);
  endtask

  task automatic t_call_overwrite;
    upd(32'h1040, 32'h4400, 2'b10, 1'b1);
    look(32'h1040);
    chk("R8 new destination", hit_target, 32'h4400);
    chk("R8 redirect", next_pc, 32'h4400);
  endtask

  task automatic t_return;
    upd(32'h1080, 32'h5000, 2'b11, 1'b1);
    look(32'h1080);
    chk("R7 use_ras", AW'(use_ras), 1);
    chk("R7 kind", AW'(hit_kind), 3);
    chk("R7 next_pc", next_pc, 32'h1084);
  endtask

  task automatic t_replace;
    // five branches mapping to the same set (stride 0x100)
    for (int i = 0; i < 5; i++)
      upd(32'h2014 + AW'(i) * 32'h100, 32'h9000 + AW'(i) * 32'h10, 2'b01, 1'b1);
    look(32'h2014);
    chk("R9 oldest evicted", AW'(hit), 0);
    for (int i = 1; i < 5; i++) begin
      look(32'h2014 + AW'(i) * 32'h100);
      chk("R9 survivor hit", AW'(hit), 1);
      chk("R9 survivor target", hit_target, 32'h9000 + AW'(i) * 32'h10);
    end
  endtask

  task automatic t_same_cycle;
    upd(32'h10C0, 32'h6000, 2'b01, 1'b1);
    @(negedge clk);
    fetch_pc = 32'h10C0;
    upd_valid = 1'b1; upd_pc = 32'h10C0; upd_target = 32'h6600;
    upd_kind = 2'b01; upd_taken = 1'b1;
    #1;
    chk("R10 old value before edge", hit_target, 32'h6000);
    @(posedge clk);
    #1;
    chk("R10 new value after edge", hit_target, 32'h6600);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_not_taken_miss();
    t_install();
    t_counter();
    t_jump_call();
    t_call_overwrite();
    t_return();
    t_replace();
    t_same_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule